// File: doc/BRIEF.md
# Dual-Axis Absolute Stepper Positioner

This block moves two stepper motor axes to absolute positions given by a host processor. The host writes a 9-bit word on a parallel bus with a one-cycle write strobe. The top bit of the word picks the axis and the low byte is the position to reach. For each axis the block holds the commanded position and the position it has reached so far. It emits one step pulse per count of distance, with a direction level that tells the driver which way to turn. Each pulse moves the position one count closer to the command.

A new command may arrive while an axis is still moving. The block then turns toward the new position without waiting for the old move to finish. A separate home request sends both axes back to their rest position of 60. The step rate comes from an input that sets the length of each pulse half-period in clock cycles. Both axes run at the same time and do not affect each other. A busy flag for each axis shows that it has not yet reached its commanded position.

Top module: `dualStepperPosCtrl`

## Requirements
- R1: A command write sets the target of the axis given by cmdData[8] (0 = first axis, 1 = second axis) to cmdData[7:0], and leaves the other axis unchanged (no step pulses on it).
- R2: After reset, both targets and positions are 60. stepOut, dirOut and busy are all low.
- R3: A written target above 248 is stored as 248.
- R4: dirOut is 1 (forward) when the target is above the current position and 0 (reverse) when it is below. Every pulse of a move that does not change direction carries that level.
- R5: A move issues exactly |target − position| step pulses. The position changes by one count on each falling edge of stepOut.
- R6: With H = halfCycles (0 is treated as 1), stepOut stays high for exactly H cycles. Consecutive rising edges in one direction are 2H+1 cycles apart.
- R7: A target written during a move replaces the old one at once. The axis ends at the new target, reversing if needed.
- R8: A one-cycle homeCmd sets both targets to 60, and both axes return there.
- R9: Both axes step at the same time when both have pending moves.
- R10: busy is high exactly while position differs from target. A step pulse rises only when the axis was busy in the cycle before.
- R11: dirOut changes only while stepOut is low, both in that cycle and the one before. It stays stable for at least H cycles before the next rising edge.
- R12: drvEnable is high from the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cmdWr | input | 1 | One-cycle strobe that writes cmdData |
| cmdData | input | 9 | [8] axis select, [7:0] target position |
| homeCmd | input | 1 | One-cycle request to send both axes to 60 |
| halfCycles | input | 16 | Clock cycles per step half-period |
| stepOut | output | 2 | Step pulse for each axis |
| dirOut | output | 2 | Direction for each axis, 1 = forward |
| busy | output | 2 | Axis has not reached its target |
| drvEnable | output | 1 | Driver enable |

## Verification
The hardest case to reach is a target change that lands while a pulse is in flight or while the axis waits with a freshly set direction. Reaching it means timing a second write against the pulse train. The bench counts falling edges from the start of a move and writes a reversing or extending target a fixed number of cycles later. An edge-counting model then confirms that the final position matches the newest command. It also confirms that the direction never changed while a pulse was high. A sweep over spread targets, the clamp edge, zero-length moves and several half-period settings covers the counting and timing rules.

// File: rtl/stepPkg.sv
package stepPkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_HIGH  = 2'd2
  } phaseT;

  // control -> datapath strobes
  typedef struct packed {
    logic advance;   // commit one count on this edge
    logic forward;   // count up when set
  } stepStrobeT;
endpackage

// File: rtl/stepAxisData.sv
module stepAxisData
  import stepPkg::*;
#(
  parameter int POS_W    = 8,
  parameter int POS_MAX  = 248,
  parameter int POS_HOME = 60
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic [POS_W-1:0] loadVal,
  input  logic             homeReq,
  input  stepStrobeT       strobe,
  output logic             atTarget,
  output logic             targetAbove
);
  localparam logic [POS_W-1:0] MaxVal  = POS_W'(POS_MAX);
  localparam logic [POS_W-1:0] HomeVal = POS_W'(POS_HOME);

  logic [POS_W-1:0] targetQ;
  logic [POS_W-1:0] posQ;
  logic [POS_W-1:0] clampedVal;

  assign clampedVal = (loadVal > MaxVal) ? MaxVal : loadVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      targetQ <= HomeVal;
    end else if (homeReq) begin
      targetQ <= HomeVal;
    end else if (loadEn) begin
      targetQ <= clampedVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posQ <= HomeVal;
    end else if (strobe.advance) begin
      if (strobe.forward) posQ <= posQ + POS_W'(1);
      else                posQ <= posQ - POS_W'(1);
    end
  end

  assign atTarget    = (targetQ == posQ);
  assign targetAbove = (targetQ > posQ);
endmodule

// File: rtl/stepAxisCtrl.sv
module stepAxisCtrl
  import stepPkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HALF_W-1:0] halfCycles,
  input  logic              atTarget,
  input  logic              targetAbove,
  output logic              stepOut,
  output logic              dirOut,
  output stepStrobeT        strobe
);
  phaseT             phaseQ;
  logic [HALF_W-1:0] cntQ;
  logic [HALF_W-1:0] lastCnt;
  logic              phaseDone;
  logic              stepQ;
  logic              dirQ;

  assign lastCnt   = (halfCycles == '0) ? '0 : halfCycles - HALF_W'(1);
  assign phaseDone = (cntQ >= lastCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      cntQ   <= '0;
      stepQ  <= 1'b0;
      dirQ   <= 1'b0;
    end else begin
      case (phaseQ)
        PH_IDLE: begin
          cntQ <= '0;
          if (!atTarget) begin
            dirQ   <= targetAbove;
            phaseQ <= PH_SETUP;
          end
        end
        PH_SETUP: begin
          if (atTarget || (targetAbove != dirQ)) begin
            cntQ   <= '0;
            phaseQ <= PH_IDLE;
          end else if (phaseDone) begin
            cntQ   <= '0;
            stepQ  <= 1'b1;
            phaseQ <= PH_HIGH;
          end else begin
            cntQ <= cntQ + HALF_W'(1);
          end
        end
        PH_HIGH: begin
          if (phaseDone) begin
            cntQ   <= '0;
            stepQ  <= 1'b0;
            phaseQ <= PH_IDLE;
          end else begin
            cntQ <= cntQ + HALF_W'(1);
          end
        end
        default: begin
          cntQ   <= '0;
          stepQ  <= 1'b0;
          phaseQ <= PH_IDLE;
        end
      endcase
    end
  end

  assign stepOut        = stepQ;
  assign dirOut         = dirQ;
  assign strobe.advance = (phaseQ == PH_HIGH) && phaseDone;
  assign strobe.forward = dirQ;
endmodule

// File: rtl/dualStepperPosCtrl.sv
module dualStepperPosCtrl
  import stepPkg::*;
#(
  parameter int AXES     = 2,
  parameter int POS_W    = 8,
  parameter int POS_MAX  = 248,
  parameter int POS_HOME = 60,
  parameter int HALF_W   = 16,
  localparam int SEL_W   = $clog2(AXES),
  localparam int CMD_W   = POS_W + SEL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWr,
  input  logic [CMD_W-1:0]  cmdData,
  input  logic              homeCmd,
  input  logic [HALF_W-1:0] halfCycles,
  output logic [AXES-1:0]   stepOut,
  output logic [AXES-1:0]   dirOut,
  output logic [AXES-1:0]   busy,
  output logic              drvEnable
);
  logic enQ;

  always_ff @(posedge clk) begin
    if (!rstN) enQ <= 1'b0;
    else       enQ <= 1'b1;
  end
  assign drvEnable = enQ;

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    logic       loadEn;
    logic       atTarget;
    logic       targetAbove;
    stepStrobeT strobe;

    assign loadEn = cmdWr && (cmdData[CMD_W-1 -: SEL_W] == SEL_W'(a));

    stepAxisData #(
      .POS_W   (POS_W),
      .POS_MAX (POS_MAX),
      .POS_HOME(POS_HOME)
    ) i_data (
      .clk        (clk),
      .rstN       (rstN),
      .loadEn     (loadEn),
      .loadVal    (cmdData[POS_W-1:0]),
      .homeReq    (homeCmd),
      .strobe     (strobe),
      .atTarget   (atTarget),
      .targetAbove(targetAbove)
    );

    stepAxisCtrl #(
      .HALF_W(HALF_W)
    ) i_ctrl (
      .clk        (clk),
      .rstN       (rstN),
      .halfCycles (halfCycles),
      .atTarget   (atTarget),
      .targetAbove(targetAbove),
      .stepOut    (stepOut[a]),
      .dirOut     (dirOut[a]),
      .strobe     (strobe)
    );

    assign busy[a] = !atTarget;
  end
endmodule

// File: rtl/stepCtrlChecker.sv
module stepCtrlChecker #(
  parameter int AXES = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            cmdWr,
  input logic            homeCmd,
  input logic [AXES-1:0] stepOut,
  input logic [AXES-1:0] dirOut,
  input logic [AXES-1:0] busy,
  input logic            drvEnable
);
  // R12
  enable_after_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> drvEnable);

  for (genvar g = 0; g < AXES; g++) begin : g_chk
    // R11
    dir_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(dirOut[g]) |-> (!stepOut[g] && !$past(stepOut[g])));

    // R10
    rise_needs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(stepOut[g]) |-> $past(busy[g]));

    // R11
    dir_hold_at_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(stepOut[g]) |-> $stable(dirOut[g]));

    // R5
    busy_drop_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(busy[g]) |-> ($fell(stepOut[g]) || $past(cmdWr) || $past(homeCmd)));
  end
endmodule

bind dualStepperPosCtrl stepCtrlChecker #(.AXES(AXES)) i_chk (.*);

// File: tb/test_dualStepperPosCtrl.sv
`timescale 1ns/100ps
module test_dualStepperPosCtrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWr = 1'b0;
  logic [8:0]  cmdData = '0;
  logic        homeCmd = 1'b0;
  logic [15:0] halfCycles = 16'd2;
  logic [1:0]  stepOut;
  logic [1:0]  dirOut;
  logic [1:0]  busy;
  logic        drvEnable;

  dualStepperPosCtrl i_dualStepperPosCtrl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdData(cmdData),
    .homeCmd(homeCmd), .halfCycles(halfCycles),
    .stepOut(stepOut), .dirOut(dirOut), .busy(busy), .drvEnable(drvEnable)
  );

  always #2.5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // edge-counting model
  int posM [2] = '{60, 60};
  int fwdP [2] = '{0, 0};
  int revP [2] = '{0, 0};
  int highLen [2] = '{0, 0};
  int lastRise [2] = '{-1, -1};
  int badHigh [2] = '{0, 0};
  int badPeriod [2] = '{0, 0};
  int badDir [2] = '{0, 0};
  bit prevStep [2] = '{0, 0};
  bit prevDir [2] = '{0, 0};
  int expHigh = 2;
  int expPeriod = 0;
  int cyc = 0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      for (int a = 0; a < 2; a++) begin
        if (dirOut[a] != prevDir[a] && (stepOut[a] || prevStep[a])) badDir[a]++;
        if (stepOut[a] && !prevStep[a]) begin
          if (dirOut[a]) fwdP[a]++; else revP[a]++;
          if (expPeriod > 0 && lastRise[a] >= 0 && (cyc - lastRise[a]) != expPeriod)
            badPeriod[a]++;
          lastRise[a] = cyc;
        end
        if (stepOut[a]) highLen[a]++;
        if (!stepOut[a] && prevStep[a]) begin
          if (highLen[a] != expHigh) badHigh[a]++;
          posM[a] += dirOut[a] ? 1 : -1;
          highLen[a] = 0;
        end
        prevStep[a] = stepOut[a];
        prevDir[a]  = dirOut[a];
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearStats();
    for (int a = 0; a < 2; a++) begin
      fwdP[a] = 0; revP[a] = 0; lastRise[a] = -1;
      badHigh[a] = 0; badPeriod[a] = 0; badDir[a] = 0;
    end
  endtask

  task automatic writeCmd(input int ax, input int t);
    @(negedge clk);
    cmdData = {ax[0], t[7:0]};
    cmdWr = 1'b1;
    @(negedge clk);
    cmdWr = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while ((busy != 2'b00 || stepOut != 2'b00) && n < 20000);
    repeat (2) @(negedge clk);
  endtask

  task automatic moveAxis(input int ax, input int t, input string req);
    int startP = posM[ax];
    int expP = (t > 248) ? 248 : t;
    int diff = expP - startP;
    clearStats();
    writeCmd(ax, t);
    check(busy[ax] == (diff != 0), "R10", "busy after write", busy[ax], diff != 0);
    waitIdle();
    check(posM[ax] == expP, req, "final position", posM[ax], expP);
    check(fwdP[ax] == ((diff > 0) ? diff : 0), "R4", "forward pulses", fwdP[ax], (diff > 0) ? diff : 0);
    check(revP[ax] == ((diff < 0) ? -diff : 0), "R5", "reverse pulses", revP[ax], (diff < 0) ? -diff : 0);
    check(fwdP[1-ax] + revP[1-ax] == 0, "R1", "pulses on other axis", fwdP[1-ax] + revP[1-ax], 0);
    check(badHigh[ax] == 0, "R6", "high width errors", badHigh[ax], 0);
    check(badDir[ax] == 0, "R11", "dir change while high", badDir[ax], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    check(stepOut == 2'b00, "R2", "step in reset", stepOut, 0);
    check(busy == 2'b00, "R2", "busy in reset", busy, 0);
    check(dirOut == 2'b00, "R2", "dir in reset", dirOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(drvEnable == 1'b1, "R12", "enable after reset", drvEnable, 1);
    check(busy == 2'b00, "R2", "busy after reset", busy, 0);

    // R1/R5 sweep over spread targets on both axes, H=2
    halfCycles = 16'd2; expHigh = 2; expPeriod = 5;
    for (int k = 0; k < 12; k++) begin
      moveAxis(k % 2, (k * 37 + 11) % 249, "R5");
    end
    moveAxis(0, 0, "R5");
    moveAxis(0, 248, "R5");
    moveAxis(0, 248, "R10");   // zero-length move
    moveAxis(1, 255, "R3");    // clamp
    moveAxis(1, 249, "R3");
    moveAxis(0, 60, "R1");
    check(badPeriod[0] + badPeriod[1] == 0, "R6", "period H=2", badPeriod[0] + badPeriod[1], 0);

    // R6 other rates
    halfCycles = 16'd5; expHigh = 5; expPeriod = 11;
    moveAxis(0, 75, "R6");
    check(badPeriod[0] == 0, "R6", "period H=5", badPeriod[0], 0);
    halfCycles = 16'd0; expHigh = 1; expPeriod = 3;
    moveAxis(0, 50, "R6");
    check(badPeriod[0] == 0, "R6", "period H=0", badPeriod[0], 0);
    check(badHigh[0] == 0, "R6", "high width H=0", badHigh[0], 0);

    // R9 both axes together
    halfCycles = 16'd2; expHigh = 2; expPeriod = 0;
    clearStats();
    writeCmd(0, 150);
    writeCmd(1, 20);
    repeat (20) @(negedge clk);
    check(busy == 2'b11, "R9", "both busy", busy, 3);
    check(fwdP[0] > 0 && revP[1] > 0, "R9", "both stepping", fwdP[0] * 1000 + revP[1], 1);
    waitIdle();
    check(posM[0] == 150, "R9", "axis0 position", posM[0], 150);
    check(posM[1] == 20, "R9", "axis1 position", posM[1], 20);

    // R7 reversing retarget mid-move
    clearStats();
    writeCmd(0, 220);
    repeat (37) @(negedge clk);
    writeCmd(0, 30);
    waitIdle();
    check(posM[0] == 30, "R7", "reversed final position", posM[0], 30);
    check(badDir[0] == 0, "R11", "dir change during retarget", badDir[0], 0);
    check(busy[0] == 1'b0, "R7", "busy after retarget", busy[0], 0);

    // R7 extending retarget and retarget timed into setup phase
    for (int d = 0; d < 6; d++) begin
      clearStats();
      writeCmd(1, 100);
      repeat (20 + d) @(negedge clk);
      writeCmd(1, (d % 2) ? 180 : 10);
      waitIdle();
      check(posM[1] == ((d % 2) ? 180 : 10), "R7", "retarget position", posM[1], (d % 2) ? 180 : 10);
      check(badDir[1] == 0, "R11", "dir change while high", badDir[1], 0);
      moveAxis(1, 30, "R7");
    end

    // R8 home during moves
    clearStats();
    writeCmd(0, 240);
    writeCmd(1, 5);
    repeat (30) @(negedge clk);
    homeCmd = 1'b1;
    @(negedge clk);
    homeCmd = 1'b0;
    waitIdle();
    check(posM[0] == 60, "R8", "axis0 home", posM[0], 60);
    check(posM[1] == 60, "R8", "axis1 home", posM[1], 60);
    check(busy == 2'b00, "R8", "busy after home", busy, 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule